// File: doc/BRIEF.md
# Watchdog Timer with Guarded Switch-Off

This block is a watchdog timer. Its counter runs on a slow, free-running clock that has no fixed relation to the system clock. Once software enables it, the counter advances on every watchdog-clock edge. When it reaches the selected timeout, the block drives a reset pulse in the system clock domain and sets a sticky flag. Software must pulse the kick input often enough to restart the count, or the reset fires.

The control register lives in the system clock domain. Setting the run bit is always accepted. Clearing it is harder on purpose, so that stray code cannot switch the watchdog off. An arming write must set the run bit and the unlock bit together. That write opens a window four system clocks long. A write that clears the run bit is honoured only inside that window. The unlock bit reads back as 1 while the window is open, and hardware clears it when the window closes.

The enable, the timeout selection and the kick cross into the watchdog domain through synchronisers. Each expiry returns to the system domain as a toggle, and an edge detector there launches the reset pulse.

Top module: `wdt_guard_top`

## Requirements
- R1: After reset the control readback `ctrl_q` is 0, and `wdt_reset_o` and `wdt_flag_o` are low.
- R2: A write with bit 0 (run) of `wr_data` at 1 sets readback bit 0 on the next clock, whatever the current state.
- R3: A write with bit 0 and bit 1 (unlock) both at 1 sets readback bit 1 for exactly four system clocks. Hardware then clears it, unless another such write re-arms it.
- R4: A write with bit 0 at 0, landing on any of the four clock edges that follow an arming write, clears readback bits 0 and 1.
- R5: A write with bit 0 at 0 outside that window leaves readback bit 0 unchanged, including a write with bit 1 set and bit 0 clear.
- R6: Bits 4:2 of every write are stored as scale n and read back at readback bits 4:2. While enabled, an expiry occurs after 2^(BASE_LOG2+n) watchdog-clock cycles without a kick.
- R7: A one-clock kick pulse clears the counter, so kicks spaced well below the timeout prevent any reset pulse.
- R8: On each expiry `wdt_reset_o` goes high for exactly PULSE_CYCLES consecutive system clocks. `wdt_flag_o` rises with it and stays high until reset.
- R9: While disabled, the counter is held at zero and no reset pulse occurs. After re-enabling, the full timeout starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| wdt_clk | input | 1 | Slow watchdog clock |
| wdt_rst | input | 1 | Synchronous active-high reset, watchdog domain |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write data: bit 0 run, bit 1 unlock, bits 4:2 scale |
| kick | input | 1 | One-clock pulse that restarts the count |
| ctrl_q | output | 5 | Readback: bit 0 run, bit 1 window open, bits 4:2 scale |
| wdt_reset_o | output | 1 | Reset pulse on expiry |
| wdt_flag_o | output | 1 | Sticky flag, set by an expiry |

## Verification
Two events can land on the same clock edge: the disable write and the hardware close of the window. The bench places a disabling write four edges after the arming write, where it must be accepted, and a second one five edges after, where it must be ignored. A behavioural model of the control register judges the readback on every clock. Expiry timing is judged against a window computed from the two clock periods and the timeout, both from a fresh enable and while kicks keep arriving.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SCALE_W = 3;
  localparam int CTRL_W  = SCALE_W + 2;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic               unlock;
    logic               run;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  wdt_ctrl_t wr_data,
  output wdt_ctrl_t ctrl_q
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0]   win_cnt, win_nxt;
  logic               run_q, run_nxt;
  logic               toe_q;
  logic [SCALE_W-1:0] scale_q;

  always_comb begin
    win_nxt = win_cnt;
    run_nxt = run_q;
    if (win_cnt != '0) win_nxt = win_cnt - WIN_W'(1);
    if (wr_en) begin
      if (wr_data.run) begin
        run_nxt = 1'b1;
        if (wr_data.unlock) win_nxt = WIN_W'(WINDOW);
      end else if (win_cnt != '0) begin
        run_nxt = 1'b0;
        win_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      win_cnt <= '0;
      toe_q   <= 1'b0;
      scale_q <= '0;
    end else begin
      run_q   <= run_nxt;
      win_cnt <= win_nxt;
      toe_q   <= (win_nxt != '0);
      if (wr_en) scale_q <= wr_data.scale;
    end
  end

  assign ctrl_q = '{scale: scale_q, unlock: toe_q, run: run_q};

  AST_RUN_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data.run) |=> run_q); // R2
  AST_TOE_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(toe_q) |-> $past(wr_en && wr_data.run && wr_data.unlock)); // R3
  AST_TOE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (toe_q && win_cnt == WIN_W'(1) && !wr_en) |=> !toe_q); // R3
  AST_OFF_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> ($past(toe_q) && $past(wr_en))); // R5
  AST_OFF_IN_WINDOW_TAKES: assert property (@(posedge clk) disable iff (rst)
    (toe_q && wr_en && !wr_data.run) |=> (!run_q && !toe_q)); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic               wdt_clk,
  input  logic               wdt_rst,
  input  logic               run_s,
  input  logic [SCALE_W-1:0] scale_s,
  input  logic               kick_evt,
  output logic               expire_tgl
);
  localparam int CNT_W = BASE_LOG2 + (1 << SCALE_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = (CNT_W'(1) << (BASE_LOG2 + int'(scale_s))) - CNT_W'(1);

  always_ff @(posedge wdt_clk) begin
    if (wdt_rst) begin
      cnt_q      <= '0;
      expire_tgl <= 1'b0;
    end else if (!run_s || kick_evt) begin
      cnt_q <= '0;
    end else if (cnt_q >= last) begin
      cnt_q      <= '0;
      expire_tgl <= ~expire_tgl;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_IDLE_HOLDS_ZERO: assert property (@(posedge wdt_clk) disable iff (wdt_rst)
    !run_s |=> (cnt_q == '0)); // R9
  AST_KICK_CLEARS: assert property (@(posedge wdt_clk) disable iff (wdt_rst)
    kick_evt |=> (cnt_q == '0)); // R7
  AST_EXPIRE_NEEDS_RUN: assert property (@(posedge wdt_clk) disable iff (wdt_rst)
    (expire_tgl != $past(expire_tgl)) |-> ($past(run_s) && !$past(kick_evt))); // R6
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire_tgl_s,
  output logic rst_o,
  output logic flag_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic          tgl_d;
  logic          evt;
  logic [PW-1:0] left_q;

  assign evt = expire_tgl_s ^ tgl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_d  <= 1'b0;
      left_q <= '0;
      rst_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      tgl_d <= expire_tgl_s;
      if (evt) begin
        left_q <= PW'(PULSE_CYCLES - 1);
        rst_o  <= 1'b1;
        flag_o <= 1'b1;
      end else if (left_q != '0) begin
        left_q <= left_q - PW'(1);
        rst_o  <= 1'b1;
      end else begin
        rst_o <= 1'b0;
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_o |=> flag_o); // R8
  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    rst_o |-> flag_o); // R8
  AST_PULSE_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> $past(evt)); // R8
endmodule

// File: rtl/wdt_guard_top.sv
module wdt_guard_top
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2    = 14,
  parameter int WINDOW       = 4,
  parameter int PULSE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_clk,
  input  logic              wdt_rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              kick,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              wdt_reset_o,
  output logic              wdt_flag_o
);
  localparam int XW = SCALE_W + 2;

  wdt_ctrl_t          wr_ctrl;
  wdt_ctrl_t          ctrl_s;
  logic               kick_tgl;
  logic [XW-1:0]      to_wdt, in_wdt;
  logic               kick_d;
  logic               kick_evt;
  logic               expire_tgl;
  logic               expire_s;

  assign wr_ctrl = wdt_ctrl_t'(wr_data);

  wdt_ctrl_reg #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_ctrl), .ctrl_q(ctrl_s)
  );

  assign ctrl_q = CTRL_W'(ctrl_s);

  always_ff @(posedge clk) begin
    if (rst) kick_tgl <= 1'b0;
    else if (kick) kick_tgl <= ~kick_tgl;
  end

  assign to_wdt = {ctrl_s.scale, ctrl_s.run, kick_tgl};

  wdt_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync_in (
    .clk(wdt_clk), .rst(wdt_rst), .d(to_wdt), .q(in_wdt)
  );

  always_ff @(posedge wdt_clk) begin
    if (wdt_rst) kick_d <= 1'b0;
    else kick_d <= in_wdt[0];
  end

  assign kick_evt = in_wdt[0] ^ kick_d;

  wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .wdt_clk(wdt_clk), .wdt_rst(wdt_rst), .run_s(in_wdt[1]),
    .scale_s(in_wdt[XW-1:2]), .kick_evt(kick_evt), .expire_tgl(expire_tgl)
  );

  wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_out (
    .clk(clk), .rst(rst), .d(expire_tgl), .q(expire_s)
  );

  wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .expire_tgl_s(expire_s),
    .rst_o(wdt_reset_o), .flag_o(wdt_flag_o)
  );
endmodule

// File: tb/wdt_guard_top_tb_top.sv
module wdt_guard_top_tb_top;
  localparam int BASE = 4;
  localparam int PULSE = 8;
  localparam int SYS_PER = 8;
  localparam int WDT_PER = 36;

  logic clk = 0, wdt_clk = 0, rst = 1, wdt_rst = 1;
  logic wr_en = 0, kick = 0;
  logic [4:0] wr_data = '0;
  logic [4:0] ctrl_q;
  logic wdt_reset_o, wdt_flag_o;

  int checks = 0, errors = 0, cycles = 0;
  int m_en = 0, m_left = 0, m_scale = 0;
  int run_len = 0, rises = 0;
  bit seen_pulse = 0, prev_rst_o = 0;

  always #(SYS_PER/2) clk = ~clk;
  always #(WDT_PER/2) wdt_clk = ~wdt_clk;

  wdt_guard_top #(.BASE_LOG2(BASE), .WINDOW(4), .PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst(rst), .wdt_clk(wdt_clk), .wdt_rst(wdt_rst),
    .wr_en(wr_en), .wr_data(wr_data), .kick(kick), .ctrl_q(ctrl_q),
    .wdt_reset_o(wdt_reset_o), .wdt_flag_o(wdt_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the control register
  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_left = 0; m_scale = 0;
    end else begin
      if (wr_en) begin
        m_scale = int'(wr_data[4:2]);
        if (wr_data[0]) begin
          m_en = 1;
          if (wr_data[1]) m_left = 4;
          else if (m_left > 0) m_left--;
        end else if (m_left > 0) begin
          m_en = 0; m_left = 0;
        end
      end else if (m_left > 0) m_left--;
    end
  end

  // Per-clock comparison and pulse monitor
  always @(negedge clk) begin
    if (!rst) begin
      int exp_ctrl;
      exp_ctrl = (m_scale << 2) | ((m_left > 0) ? 2 : 0) | m_en;
      chk(int'(ctrl_q) == exp_ctrl, "R2/R3/R4/R5/R6 readback", int'(ctrl_q), exp_ctrl);
      if (wdt_reset_o) begin
        if (!prev_rst_o) rises++;
        run_len++;
        seen_pulse = 1;
      end else if (prev_rst_o) begin
        chk(run_len == PULSE, "R8 pulse length", run_len, PULSE);
        run_len = 0;
      end
      chk(wdt_flag_o == seen_pulse, "R8 sticky flag", wdt_flag_o, seen_pulse);
      prev_rst_o = wdt_reset_o;
    end
  end

  task automatic wr(input bit run, input bit unlock, input int sc);
    wr_en = 1; wr_data = {sc[2:0], unlock, run};
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic disable_wd(input int sc);
    wr(1, 1, sc);
    wr(0, 0, sc);
    idle(40);
  endtask

  task automatic measure(input int sc, input string req);
    int n, lim, lo, hi;
    lim = 1 << (BASE + sc);
    lo = lim * WDT_PER / SYS_PER;
    hi = (lim + 6) * WDT_PER / SYS_PER + 8;
    wr(1, 0, sc);
    n = 1;
    while (!wdt_reset_o && n < hi + 50) begin @(negedge clk); n++; end
    chk(n >= lo && n <= hi, req, n, lo);
    idle(PULSE + 4);
  endtask

  initial begin
    int r0;
    idle(20);
    rst = 0; wdt_rst = 0;
    @(negedge clk);
    chk(ctrl_q == 5'd0, "R1 readback after reset", ctrl_q, 0);
    chk(wdt_reset_o == 0, "R1 reset output low", wdt_reset_o, 0);
    chk(wdt_flag_o == 0, "R1 flag low", wdt_flag_o, 0);

    // R6 R8: timeout from fresh enable, scale 2
    measure(2, "R6 timeout scale 2");
    chk(wdt_flag_o == 1, "R8 flag after expiry", wdt_flag_o, 1);

    // R7: kicks keep it quiet
    r0 = rises;
    for (int k = 0; k < 100; k++) begin
      kick = 1; @(negedge clk); kick = 0; idle(19);
    end
    chk(rises == r0, "R7 no pulse while kicked", rises - r0, 0);

    // R3: window readback for exactly four clocks
    wr(1, 1, 2);
    for (int i = 0; i < 5; i++) begin
      chk(ctrl_q[1] == (i < 4), "R3 window bit", ctrl_q[1], (i < 4));
      @(negedge clk);
    end

    // R4: disable landing on the fourth edge after arming is accepted
    wr(1, 1, 2);
    idle(3);
    wr(0, 0, 2);
    chk(ctrl_q[1:0] == 2'b00, "R4 disable on last window edge", ctrl_q[1:0], 0);

    // R9: no pulse while disabled
    r0 = rises;
    idle(1500);
    chk(rises == r0, "R9 no pulse while disabled", rises - r0, 0);
    chk(wdt_flag_o == 1, "R8 flag still set", wdt_flag_o, 1);

    // R2: enable always accepted; R5: disable on fifth edge ignored
    wr(1, 0, 2);
    chk(ctrl_q[0] == 1, "R2 enable accepted", ctrl_q[0], 1);
    wr(1, 1, 2);
    idle(4);
    wr(0, 0, 2);
    chk(ctrl_q[0] == 1, "R5 late disable ignored", ctrl_q[0], 1);
    wr(0, 1, 2);
    wr(0, 0, 2);
    chk(ctrl_q[0] == 1, "R5 disable without arming ignored", ctrl_q[0], 1);

    // R9: re-enable after disable restarts full timeout
    disable_wd(2);
    measure(2, "R9 restart from zero");

    // R6: other scales
    disable_wd(0);
    measure(0, "R6 timeout scale 0");
    disable_wd(5);
    chk(ctrl_q[4:2] == 3'd5, "R6 scale readback", ctrl_q[4:2], 5);
    measure(5, "R6 timeout scale 5");
    disable_wd(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule